// File: doc/BRIEF.md
# Thermal Warning Gain Limiter

This controller sits between the thermal warning line of an amplifier power stage and the gain stage of the audio datapath. The warning input is active low. Once it has stayed low for longer than a qualification time, measured in millisecond ticks, the controller engages a fixed gain cut. It shows this on an "adjustment active" flag and hands the post-scale attenuation code to the datapath, which performs the multiply.

Two control bits govern the behaviour. The adjustment-bypass bit disables the feature completely. The recovery-bypass bit decides what happens when the warning goes away. When it is 0, full gain returns as soon as the warning clears. When it is 1, the cut stays latched until software clears the bit or the block is reset. The attenuation is a code in 0.5 dB steps. A code of 6 gives the usual -3 dB cut.

Top module: `thermal_gain_limiter`

## Requirements
- R1: After reset, `adjActive` is 0 and `attenCode` is 0.
- R2: With `adjBypass`=0, the cut engages when `warnN` has stayed at 0 (the warning is present) across `QUAL_MS`+1 `msTick` pulses. `adjActive` rises on the clock edge that samples the qualifying tick.
- R3: If `warnN` returns to 1 before qualification completes, the tick count clears. A later warning then needs the full `QUAL_MS`+1 ticks again. Exactly `QUAL_MS` ticks never engage the cut.
- R4: While `adjBypass`=1, the cut never engages. If the cut is active when `adjBypass` becomes 1, it is removed on the next clock edge.
- R5: With `recBypass`=0, an active cut is removed on the clock edge that first samples `warnN`=1.
- R6: With `recBypass`=1, an active cut stays after `warnN` returns to 1. It is released on the clock edge that samples `recBypass`=0 while `warnN`=1.
- R7: `attenCode` equals the `postScale` value sampled on the same edge while the cut is active, and 0 otherwise. The code is in 0.5 dB steps, so 6 means -3 dB.
- R8: While the cut is active and `warnN` is at 0, the cut stays active, whatever the value of `recBypass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| warnN | input | 1 | Thermal warning, 0 = warning present |
| msTick | input | 1 | One-cycle pulse every millisecond |
| adjBypass | input | 1 | 1 disables the thermal adjustment |
| recBypass | input | 1 | 1 keeps the cut after the warning clears |
| postScale | input | GAIN_W | Attenuation code in 0.5 dB steps |
| adjActive | output | 1 | Cut is engaged |
| attenCode | output | GAIN_W | Attenuation handed to the datapath, 0 when idle |

## Verification
The assertions assume that `warnN` is already synchronous to `clk` and that `msTick` is a single-cycle pulse. They also assume that `postScale` may change on any cycle, and that the output tracks the sampled value. The bench therefore drives every input once per cycle, after the falling edge. It holds the warning low for long random runs, so that qualification is actually reached. It inserts short releases to exercise the counter restart, and it toggles the bypass bits only rarely, so that both the sticky and the releasing paths get time to act.

// File: rtl/thermlim_pkg.sv
package thermlim_pkg;
  typedef struct packed {
    logic clearCnt;
    logic stepCnt;
    logic gainOn;
  } ctlStrobes_t;
endpackage

// File: rtl/thermlim_dpath.sv
module thermlim_dpath
  import thermlim_pkg::*;
#(
  parameter int QUAL_MS = 400,
  parameter int GAIN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [GAIN_W-1:0] postScale,
  output logic              qualDone,
  output logic [GAIN_W-1:0] attenCode
);
  localparam int CNT_W = $clog2(QUAL_MS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_MS);

  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.clearCnt) begin
      tickCnt <= '0;
    end else if (strb.stepCnt && tickCnt != CNT_LAST) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign qualDone = (tickCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      attenCode <= '0;
    end else begin
      attenCode <= strb.gainOn ? postScale : '0;
    end
  end
endmodule

// File: rtl/thermlim_ctrl.sv
module thermlim_ctrl
  import thermlim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        warnN,
  input  logic        msTick,
  input  logic        adjBypass,
  input  logic        recBypass,
  input  logic        qualDone,
  output ctlStrobes_t strb,
  output logic        holdQ
);
  logic holdNext;
  logic qualHit;

  assign qualHit = !warnN && msTick && qualDone;

  always_comb begin
    if (adjBypass) begin
      holdNext = 1'b0;
    end else if (holdQ) begin
      holdNext = !(warnN && !recBypass);
    end else begin
      holdNext = qualHit;
    end
  end

  always_comb begin
    strb.clearCnt = adjBypass || warnN || holdQ || qualHit;
    strb.stepCnt  = !strb.clearCnt && msTick;
    strb.gainOn   = holdNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdQ <= 1'b0;
    else       holdQ <= holdNext;
  end
endmodule

// File: rtl/thermal_gain_limiter.sv
module thermal_gain_limiter
  import thermlim_pkg::*;
#(
  parameter int QUAL_MS = 400,
  parameter int GAIN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              warnN,
  input  logic              msTick,
  input  logic              adjBypass,
  input  logic              recBypass,
  input  logic [GAIN_W-1:0] postScale,
  output logic              adjActive,
  output logic [GAIN_W-1:0] attenCode
);
  ctlStrobes_t strb;
  logic qualDone;

  thermlim_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .warnN(warnN), .msTick(msTick),
    .adjBypass(adjBypass), .recBypass(recBypass), .qualDone(qualDone),
    .strb(strb), .holdQ(adjActive)
  );

  thermlim_dpath #(.QUAL_MS(QUAL_MS), .GAIN_W(GAIN_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .postScale(postScale),
    .qualDone(qualDone), .attenCode(attenCode)
  );
endmodule

// File: rtl/thermlim_checker.sv
module thermlim_checker #(
  parameter int QUAL_MS = 400,
  parameter int GAIN_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              warnN,
  input logic              msTick,
  input logic              adjBypass,
  input logic              recBypass,
  input logic [GAIN_W-1:0] postScale,
  input logic              adjActive,
  input logic [GAIN_W-1:0] attenCode
);
  localparam int SEEN_W = $clog2(QUAL_MS + 2) + 1;
  logic [SEEN_W-1:0] seenTicks;

  always_ff @(posedge clk) begin
    if (!rstN || warnN || adjBypass || adjActive) seenTicks <= '0;
    else if (msTick) seenTicks <= seenTicks + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |=> (!adjActive && attenCode == '0)); // R1
  AST_ENGAGE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adjActive) |-> $past(!warnN && msTick)); // R2
  AST_QUAL_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adjActive) |-> (seenTicks == SEEN_W'(QUAL_MS + 1))); // R3
  AST_BYPASS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    adjBypass |=> !adjActive); // R4
  AST_RELEASE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (adjActive && warnN && !recBypass) |=> !adjActive); // R5
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (adjActive && !adjBypass && recBypass) |=> adjActive); // R6
  AST_CODE_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !adjActive |-> (attenCode == '0)); // R7
  AST_CODE_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (adjActive && $past(rstN)) |-> (attenCode == $past(postScale))); // R7
  AST_HOLD_WHILE_WARN: assert property (@(posedge clk) disable iff (!rstN)
    (adjActive && !adjBypass && !warnN) |=> adjActive); // R8
endmodule

bind thermal_gain_limiter thermlim_checker #(.QUAL_MS(QUAL_MS), .GAIN_W(GAIN_W)) uChk (
  .clk(clk), .rstN(rstN), .warnN(warnN), .msTick(msTick),
  .adjBypass(adjBypass), .recBypass(recBypass), .postScale(postScale),
  .adjActive(adjActive), .attenCode(attenCode)
);

// File: tb/thermal_gain_limiter_test.sv
module thermal_gain_limiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL_MS = 400;
  localparam int GAIN_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic warnN = 1'b1, msTick = 1'b0, adjBypass = 1'b1, recBypass = 1'b1;
  logic [GAIN_W-1:0] postScale = 8'd6;
  logic adjActive;
  logic [GAIN_W-1:0] attenCode;

  int checks = 0, fails = 0;
  int mCnt = 0;
  bit mActive = 1'b0;
  logic [GAIN_W-1:0] mCode = '0;

  thermal_gain_limiter #(.QUAL_MS(QUAL_MS), .GAIN_W(GAIN_W)) uut (
    .clk(clk), .rstN(rstN), .warnN(warnN), .msTick(msTick),
    .adjBypass(adjBypass), .recBypass(recBypass), .postScale(postScale),
    .adjActive(adjActive), .attenCode(attenCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [GAIN_W-1:0] expCode(bit act, logic [GAIN_W-1:0] ps);
    return act ? ps : '0;
  endfunction

  task automatic check(string req, logic [GAIN_W:0] act, logic [GAIN_W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive after falling edge, model the edge, compare after the next falling edge
  task automatic step(bit w, bit t, bit ab, bit rb, logic [GAIN_W-1:0] ps, string req);
    warnN = w; msTick = t; adjBypass = ab; recBypass = rb; postScale = ps;
    if (ab) begin
      mActive = 1'b0; mCnt = 0;
    end else if (mActive) begin
      if (w && !rb) mActive = 1'b0;
      mCnt = 0;
    end else if (w) begin
      mCnt = 0;
    end else if (t) begin
      if (mCnt == QUAL_MS) begin mActive = 1'b1; mCnt = 0; end
      else mCnt++;
    end
    mCode = expCode(mActive, ps);
    @(negedge clk);
    check(req, {adjActive, attenCode}, {mActive, mCode});
  endtask

  task automatic ticks(int n, bit w, bit ab, bit rb, logic [GAIN_W-1:0] ps, string req);
    for (int i = 0; i < n; i++) begin
      step(w, 1'b0, ab, rb, ps, req);
      step(w, 1'b1, ab, rb, ps, req);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", {adjActive, attenCode}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {adjActive, attenCode}, '0);

    // R3: exactly QUAL_MS ticks do not engage, then a clear restarts
    ticks(QUAL_MS, 1'b0, 1'b0, 1'b0, 8'd6, "R3");
    check("R3", {1'b0, adjActive}, 9'd0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'd6, "R3");
    ticks(QUAL_MS, 1'b0, 1'b0, 1'b0, 8'd6, "R3");
    check("R3", {1'b0, adjActive}, 9'd0);
    // R2: one more tick engages
    ticks(1, 1'b0, 1'b0, 1'b0, 8'd6, "R2");
    check("R2", {adjActive, attenCode}, {1'b1, 8'd6});
    // R7 / R8: code tracks while warning persists
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'd10, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'd4, "R8");
    // R5: release when warning clears
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'd6, "R5");
    check("R5", {1'b0, adjActive}, 9'd0);
    // R6: sticky hold, release on recBypass clear
    ticks(QUAL_MS + 1, 1'b0, 1'b0, 1'b1, 8'd6, "R2");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 8'd6, "R6");
    check("R6", {1'b0, adjActive}, 9'd1);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'd6, "R6");
    check("R6", {1'b0, adjActive}, 9'd0);
    // R4: bypass stops qualification and drops an active cut
    ticks(QUAL_MS + 3, 1'b0, 1'b1, 1'b0, 8'd6, "R4");
    ticks(QUAL_MS + 1, 1'b0, 1'b0, 1'b1, 8'd6, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'd6, "R4");
    check("R4", {adjActive, attenCode}, '0);

    // Constrained random phase
    begin
      bit w = 1'b1, ab = 1'b0, rb = 1'b0;
      logic [GAIN_W-1:0] ps = 8'd6;
      for (int n = 0; n < 60000; n++) begin
        if ($urandom_range(0, 999) < 2) w = ~w;
        if ($urandom_range(0, 9999) < 3) ab = ~ab;
        if ($urandom_range(0, 9999) < 5) rb = ~rb;
        if ($urandom_range(0, 999) < 3) ps = 8'($urandom_range(0, 255));
        step(w, ($urandom_range(0, 3) == 0), ab, rb, ps, "R7");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule